// File: doc/BRIEF.md
# Serial Command Front End for a Dual Programmable Resistor

This block receives fixed-length 24-bit command frames over a four-wire serial link. It hands each complete frame to the command executor of a dual-channel, 1024-step digitally controlled resistor. The serial pins are first brought into the system clock domain and edge-detected, so every register in the block runs on one clock. Data bits are taken on rising serial-clock edges, most significant bit first, while chip select is low. A frame is acted on only when chip select returns high. At that point the block presents a command code, an address and a data field to the core, together with a single-cycle execute strobe.

The serial output is open drain. By default it replays the incoming bit stream exactly 24 serial clocks late, so several devices can share one chain. After a frame that carries one of the two readback codes (9 for the wiper setting, 10 for the stored setting), the next frame does something else. During that frame the output shifts out a 10-bit value supplied by the executor, right-aligned in a 24-bit word. Chip-select windows whose bit count is not a whole multiple of 24 are dropped.

Top module: `dpot_serial_frontend`

## Requirements
- R1: While reset is held, `exec_strobe` and `sdo_pull_low` are 0, and `cmd_code`, `chan_addr` and `data_field` are all zero.
- R2: After a 24-bit window, frame bits [23:20] appear on `cmd_code`, [19:16] on `chan_addr` and [9:0] on `data_field`. Bits are sent MSB first, and bits [15:10] have no effect.
- R3: A valid window gives exactly one `exec_strobe` pulse, one system clock wide. The pulse follows the rise of chip select; there is none while bits are still shifting.
- R4: A window whose bit count is not a multiple of 24 gives no strobe and leaves the three field outputs unchanged.
- R5: A window of 48 bits is valid, and its last 24 bits are the frame that gets decoded.
- R6: Outside readback frames, the serial-output level seen at each rising serial-clock edge equals the data-input bit taken 24 rising edges earlier. This holds across window boundaries, and the stream starts as zeros after reset.
- R7: In the window right after a valid frame with command 9 or 10, the serial output carries 14 zeros and then the 10-bit `rd_data` value, MSB first. `rd_data` is sampled when chip select falls.
- R8: Readback output lasts for one window only. The following window returns to the 24-clock delayed echo, and a dropped window also cancels a pending readback.
- R9: `sdo_pull_low` is high only when chip select is low and the output bit is 0. It is released whenever chip select is high, including during the strobe.
- R10: Serial-clock activity while chip select is high shifts nothing and produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_in | input | 1 | Serial clock pin, asynchronous to clk |
| csn_in | input | 1 | Chip select pin, active low |
| mosi_in | input | 1 | Serial data in |
| rd_data | input | 10 | Readback value from the executor |
| sdo_pull_low | output | 1 | Open-drain enable; 1 pulls the serial output low |
| exec_strobe | output | 1 | One-cycle command execute pulse |
| cmd_code | output | 4 | Decoded command code |
| chan_addr | output | 4 | Channel address (0 selects wiper 1, 1 selects wiper 2) |
| data_field | output | 10 | Data field |

## Verification
The hardest situation to reach is the switch between the delayed echo and readback output. A readback frame has to be followed by a window whose output comes from the executor rather than from the stream. After that, the echo must resume with bits that were shifted in while readback was driving the pin. The vector table places readback commands back to back with ordinary frames. It also puts a 13-bit and a 30-bit window and a 48-bit window inside that sequence. The bench keeps its own 24-bit history of every bit it has sent and checks the output at every rising edge. Stray serial clocks with chip select high are sent last, to show that the history did not move.

// File: rtl/dpot_spi_pkg.sv
package dpot_spi_pkg;
   localparam int unsigned FRAME_BITS_DEF = 24;
   localparam int unsigned CMD_W_DEF      = 4;
   localparam int unsigned ADDR_W_DEF     = 4;
   localparam int unsigned DATA_W_DEF     = 10;
   localparam int unsigned SYNC_DEF       = 2;

   // pin slot order inside the synchroniser bank
   typedef enum int unsigned {
      PIN_SCLK = 0,
      PIN_CSN  = 1,
      PIN_MOSI = 2
   } pin_slot_e;

   localparam int unsigned PIN_COUNT = 3;
endpackage

// File: rtl/dpot_sync_edge.sv
module dpot_sync_edge #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic level,
   output logic rise,
   output logic fall
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("dpot_sync_edge: STAGES must be at least 2");
      end
   endgenerate

   // chain[STAGES-1] is the synchronised level, chain[STAGES] its previous value
   logic [STAGES:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {(STAGES+1){RST_VAL}};
      else        chain <= {chain[STAGES-1:0], din};
   end

   assign level = chain[STAGES-1];
   assign rise  =  chain[STAGES-1] & ~chain[STAGES];
   assign fall  = ~chain[STAGES-1] &  chain[STAGES];
endmodule

// File: rtl/dpot_frame_shifter.sv
module dpot_frame_shifter #(
   parameter int unsigned FRAME_BITS = 24
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  frame_start,
   input  logic                  shift_en,
   input  logic                  bit_in,
   output logic [FRAME_BITS-1:0] frame,
   output logic                  frame_whole
);
   localparam int unsigned        CNT_W = $clog2(FRAME_BITS);
   localparam logic [CNT_W-1:0]   LAST  = CNT_W'(FRAME_BITS - 1);

   generate
      if (FRAME_BITS < 8) begin : g_bad_frame
         $error("dpot_frame_shifter: FRAME_BITS too small");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic             got_any;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) frame <= '0;
      else if (shift_en) frame <= {frame[FRAME_BITS-2:0], bit_in};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         got_any <= 1'b0;
      end else if (frame_start) begin
         cnt     <= '0;
         got_any <= 1'b0;
      end else if (shift_en) begin
         cnt     <= (cnt == LAST) ? '0 : cnt + 1'b1;
         got_any <= 1'b1;
      end
   end

   assign frame_whole = got_any && (cnt == '0);
endmodule

// File: rtl/dpot_cmd_latch.sv
module dpot_cmd_latch #(
   parameter int unsigned        FRAME_BITS = 24,
   parameter int unsigned        CMD_W      = 4,
   parameter int unsigned        ADDR_W     = 4,
   parameter int unsigned        DATA_W     = 10,
   parameter logic [CMD_W-1:0]   RB_CODE_A  = CMD_W'(9),
   parameter logic [CMD_W-1:0]   RB_CODE_B  = CMD_W'(10)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  frame_end,
   input  logic                  frame_whole,
   input  logic [FRAME_BITS-1:0] frame,
   output logic [CMD_W-1:0]      cmd_code,
   output logic [ADDR_W-1:0]     chan_addr,
   output logic [DATA_W-1:0]     data_field,
   output logic                  exec_strobe,
   output logic                  rb_armed
);
   localparam int unsigned CMD_LSB  = FRAME_BITS - CMD_W;
   localparam int unsigned ADDR_LSB = CMD_LSB - ADDR_W;

   generate
      if (ADDR_LSB <= DATA_W) begin : g_bad_layout
         $error("dpot_cmd_latch: fields overlap or leave no spare bits");
      end
   endgenerate

   logic [CMD_W-1:0] cmd_next;
   logic             unused_spare;

   assign cmd_next     = frame[FRAME_BITS-1:CMD_LSB];
   assign unused_spare = ^frame[ADDR_LSB-1:DATA_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_code    <= '0;
         chan_addr   <= '0;
         data_field  <= '0;
         exec_strobe <= 1'b0;
         rb_armed    <= 1'b0;
      end else begin
         exec_strobe <= 1'b0;
         if (frame_end) begin
            if (frame_whole) begin
               cmd_code    <= cmd_next;
               chan_addr   <= frame[CMD_LSB-1:ADDR_LSB];
               data_field  <= frame[DATA_W-1:0];
               exec_strobe <= 1'b1;
               rb_armed    <= (cmd_next == RB_CODE_A) || (cmd_next == RB_CODE_B);
            end else begin
               rb_armed    <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/dpot_sdo_driver.sv
module dpot_sdo_driver #(
   parameter int unsigned FRAME_BITS = 24,
   parameter int unsigned DATA_W     = 10,
   parameter bit          OUT_REG    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_act,
   input  logic              cs_fall,
   input  logic              sclk_fall,
   input  logic              chain_bit,
   input  logic              rb_armed,
   input  logic [DATA_W-1:0] rd_data,
   output logic              sdo_pull_low
);
   generate
      if (DATA_W > FRAME_BITS) begin : g_bad_width
         $error("dpot_sdo_driver: DATA_W exceeds FRAME_BITS");
      end
   endgenerate

   logic                  rb_active;
   logic [FRAME_BITS-1:0] rb_sr;
   logic                  dly_q;
   logic                  out_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rb_active <= 1'b0;
         rb_sr     <= '0;
         dly_q     <= 1'b0;
      end else if (cs_fall) begin
         rb_active <= rb_armed;
         rb_sr     <= FRAME_BITS'(rd_data);
      end else if (sclk_fall && cs_act) begin
         dly_q     <= chain_bit;
         rb_sr     <= {rb_sr[FRAME_BITS-2:0], 1'b0};
      end
   end

   assign out_bit = rb_active ? rb_sr[FRAME_BITS-1] : dly_q;

   generate
      if (OUT_REG) begin : g_reg_out
         logic pull_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pull_q <= 1'b0;
            else        pull_q <= cs_act & ~out_bit;
         end
         assign sdo_pull_low = pull_q;
      end else begin : g_comb_out
         assign sdo_pull_low = cs_act & ~out_bit;
      end
   endgenerate
endmodule

// File: rtl/dpot_serial_frontend.sv
module dpot_serial_frontend
   import dpot_spi_pkg::*;
#(
   parameter int unsigned FRAME_BITS = FRAME_BITS_DEF,
   parameter int unsigned CMD_W      = CMD_W_DEF,
   parameter int unsigned ADDR_W     = ADDR_W_DEF,
   parameter int unsigned DATA_W     = DATA_W_DEF,
   parameter int unsigned SYNC_STG   = SYNC_DEF,
   parameter bit          OUT_REG    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_in,
   input  logic              csn_in,
   input  logic              mosi_in,
   input  logic [DATA_W-1:0] rd_data,
   output logic              sdo_pull_low,
   output logic              exec_strobe,
   output logic [CMD_W-1:0]  cmd_code,
   output logic [ADDR_W-1:0] chan_addr,
   output logic [DATA_W-1:0] data_field
);
   localparam logic [PIN_COUNT-1:0] PIN_RST = PIN_COUNT'(1) << PIN_CSN;

   logic [PIN_COUNT-1:0] pin_raw, pin_lvl, pin_rise, pin_fall;

   assign pin_raw[PIN_SCLK] = sclk_in;
   assign pin_raw[PIN_CSN]  = csn_in;
   assign pin_raw[PIN_MOSI] = mosi_in;

   for (genvar p = 0; p < PIN_COUNT; p++) begin : g_sync
      dpot_sync_edge #(.STAGES(SYNC_STG), .RST_VAL(PIN_RST[p])) i_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .din   (pin_raw[p]),
         .level (pin_lvl[p]),
         .rise  (pin_rise[p]),
         .fall  (pin_fall[p])
      );
   end

   logic cs_act, cs_rise_p, cs_fall_p, shift_en, sclk_fall_p;
   logic unused_edges;

   assign cs_act       = ~pin_lvl[PIN_CSN];
   assign cs_rise_p    = pin_rise[PIN_CSN];
   assign cs_fall_p    = pin_fall[PIN_CSN];
   assign shift_en     = pin_rise[PIN_SCLK] & cs_act;
   assign sclk_fall_p  = pin_fall[PIN_SCLK];
   assign unused_edges = pin_lvl[PIN_SCLK] ^ pin_rise[PIN_MOSI] ^ pin_fall[PIN_MOSI];

   logic [FRAME_BITS-1:0] frame;
   logic                  frame_whole;
   logic                  rb_armed;

   dpot_frame_shifter #(.FRAME_BITS(FRAME_BITS)) i_shift (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (cs_fall_p),
      .shift_en    (shift_en),
      .bit_in      (pin_lvl[PIN_MOSI]),
      .frame       (frame),
      .frame_whole (frame_whole)
   );

   dpot_cmd_latch #(
      .FRAME_BITS (FRAME_BITS),
      .CMD_W      (CMD_W),
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W)
   ) i_latch (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_end   (cs_rise_p),
      .frame_whole (frame_whole),
      .frame       (frame),
      .cmd_code    (cmd_code),
      .chan_addr   (chan_addr),
      .data_field  (data_field),
      .exec_strobe (exec_strobe),
      .rb_armed    (rb_armed)
   );

   dpot_sdo_driver #(
      .FRAME_BITS (FRAME_BITS),
      .DATA_W     (DATA_W),
      .OUT_REG    (OUT_REG)
   ) i_sdo (
      .clk          (clk),
      .rst_n        (rst_n),
      .cs_act       (cs_act),
      .cs_fall      (cs_fall_p),
      .sclk_fall    (sclk_fall_p),
      .chain_bit    (frame[FRAME_BITS-1]),
      .rb_armed     (rb_armed),
      .rd_data      (rd_data),
      .sdo_pull_low (sdo_pull_low)
   );
endmodule

// File: rtl/dpot_serial_frontend_chk.sv
module dpot_serial_frontend_chk #(
   parameter int unsigned CMD_W  = 4,
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DATA_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              exec_strobe,
   input logic              sdo_pull_low,
   input logic [CMD_W-1:0]  cmd_code,
   input logic [ADDR_W-1:0] chan_addr,
   input logic [DATA_W-1:0] data_field,
   input logic              cs_rise_p,
   input logic              cs_act
);
   // R3
   strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exec_strobe |=> !exec_strobe);

   // R3
   strobe_after_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exec_strobe |-> $past(cs_rise_p));

   // R4
   fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !exec_strobe |-> ($stable(cmd_code) && $stable(chan_addr) && $stable(data_field)));

   // R9
   release_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exec_strobe |-> !sdo_pull_low);

   // R10
   idle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_act && $past(!cs_act) && !$past(cs_rise_p)) |-> !exec_strobe);
endmodule

bind dpot_serial_frontend dpot_serial_frontend_chk #(
   .CMD_W  (CMD_W),
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .exec_strobe  (exec_strobe),
   .sdo_pull_low (sdo_pull_low),
   .cmd_code     (cmd_code),
   .chan_addr    (chan_addr),
   .data_field   (data_field),
   .cs_rise_p    (cs_rise_p),
   .cs_act       (cs_act)
);

// File: tb/test_dpot_serial_frontend.sv
module test_dpot_serial_frontend;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sclk = 1'b0;
   logic       csn = 1'b1;
   logic       mosi = 1'b0;
   logic [9:0] rd_data;
   logic       sdo_pull_low, exec_strobe;
   logic [3:0] cmd_code, chan_addr;
   logic [9:0] data_field;

   always #10 clk = ~clk;

   dpot_serial_frontend i_dpot_serial_frontend (
      .clk(clk), .rst_n(rst_n), .sclk_in(sclk), .csn_in(csn), .mosi_in(mosi),
      .rd_data(rd_data), .sdo_pull_low(sdo_pull_low), .exec_strobe(exec_strobe),
      .cmd_code(cmd_code), .chan_addr(chan_addr), .data_field(data_field));

   // executor stub: readback value depends on the command and channel
   function automatic logic [9:0] stub_val(input logic [3:0] c, input logic [3:0] a);
      if (c == 4'd9) return (a == 4'd1) ? 10'h2AB : 10'h155;
      return 10'h3C0 ^ {6'b0, a};
   endfunction

   always_comb rd_data = stub_val(cmd_code, chan_addr);

   int n_strobe = 0;
   always @(posedge clk) if (rst_n && exec_strobe) n_strobe++;

   int checks = 0, errs = 0;
   bit done = 1'b0;
   logic [23:0] bh = '0;
   logic        exp_rb = 1'b0, prev_rb = 1'b0;
   logic [3:0]  e_cmd = '0, e_addr = '0;
   logic [9:0]  e_data = '0;

   typedef struct packed {
      logic [47:0] word;
      logic [5:0]  nbits;
   } vec_t;

   localparam vec_t VECS [9] = '{
      '{48'h00000010FD55, 6'd24},   // R2 spare bits set
      '{48'h000000910000, 6'd24},   // readback wiper, channel 2
      '{48'h0000000003FF, 6'd24},   // R7 readback frame
      '{48'h000000A00000, 6'd24},   // R8 echo resumes, arms stored readback
      '{48'h0000002102AA, 6'd24},   // R7 second readback
      '{48'h000000001ABC, 6'd13},   // R4 short window
      '{48'h1234567101A5, 6'd48},   // R5 double-length window
      '{48'h00003FFFFFFF, 6'd30},   // R4 odd window
      '{48'h000000F057FF, 6'd24}    // R2 highest code
   };

   task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_frame(input logic [47:0] w, input int n);
      int          start;
      logic [23:0] rbw;
      logic [23:0] fr;
      string       tag;
      rbw = {14'b0, stub_val(e_cmd, e_addr)};
      tag = exp_rb ? "R7" : (prev_rb ? "R8" : "R6");
      start = n_strobe;
      csn = 1'b0;
      wait_n(10);
      for (int i = n - 1; i >= 0; i--) begin
         int   k;
         logic expb;
         k = n - 1 - i;
         if (exp_rb) expb = (k < 24) ? rbw[23 - k] : 1'b0;
         else        expb = bh[23];
         mosi = w[i];
         wait_n(6);
         chk((!sdo_pull_low) == expb, tag, 32'(!sdo_pull_low), 32'(expb));
         bh = {bh[22:0], w[i]};
         sclk = 1'b1;
         wait_n(6);
         sclk = 1'b0;
      end
      wait_n(6);
      chk(n_strobe == start, "R3 no strobe while shifting", n_strobe, start);
      csn = 1'b1;
      wait_n(12);
      chk(sdo_pull_low == 1'b0, "R9 released", 32'(sdo_pull_low), 0);
      prev_rb = exp_rb;
      if (n % 24 == 0) begin
         fr     = w[23:0];
         e_cmd  = fr[23:20];
         e_addr = fr[19:16];
         e_data = fr[9:0];
         exp_rb = (e_cmd == 4'd9) || (e_cmd == 4'd10);
         chk(n_strobe == start + 1, "R3 one strobe", n_strobe - start, 1);
      end else begin
         exp_rb = 1'b0;
         chk(n_strobe == start, "R4 no strobe", n_strobe - start, 0);
      end
      chk(cmd_code == e_cmd, (n == 48) ? "R5 cmd" : "R2 cmd", cmd_code, e_cmd);
      chk(chan_addr == e_addr, (n == 48) ? "R5 addr" : "R2 addr", chan_addr, e_addr);
      chk(data_field == e_data, (n % 24 != 0) ? "R4 data" : "R2 data", data_field, e_data);
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", errs, checks);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errs++;
         $display("FAIL watchdog expired actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      wait_n(4);
      // R1 reset state
      chk(exec_strobe == 1'b0, "R1 strobe", 32'(exec_strobe), 0);
      chk(sdo_pull_low == 1'b0, "R1 sdo", 32'(sdo_pull_low), 0);
      chk({cmd_code, chan_addr, data_field} == '0, "R1 fields",
          32'({cmd_code, chan_addr, data_field}), 0);
      rst_n = 1'b1;
      wait_n(5);

      for (int v = 0; v < 9; v++) begin
         send_frame(VECS[v].word, int'(VECS[v].nbits));
      end

      // R10: serial clocks with chip select high
      begin
         int start;
         start = n_strobe;
         for (int t = 0; t < 7; t++) begin
            mosi = t[0];
            wait_n(6);
            sclk = 1'b1;
            wait_n(6);
            sclk = 1'b0;
         end
         wait_n(12);
         chk(n_strobe == start, "R10 no strobe", n_strobe - start, 0);
         chk(sdo_pull_low == 1'b0, "R10 sdo idle", 32'(sdo_pull_low), 0);
      end
      // echo history must be untouched by the stray clocks (R10)
      send_frame(48'h000000355001, 24);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule